// File: doc/BRIEF.md
# Clear-on-read interrupt aggregator

This block gathers single-cycle event pulses from internal sources into a set of 8-bit pending registers and reduces them to one interrupt request line. A host handles the line by first reading a summary register, which shows which pending registers hold anything. It then reads those pending registers. Each read of a pending register returns its contents and empties it. The request line goes inactive once every enabled pending bit has been read away.

Each pending bit has a static enable. A disabled bit still records and still reads back, but it does not drive the request line. A 2-bit drive field selects how the request pin is driven. In open-drain style the pin is driven low only while a request is active and is left floating otherwise. In push-pull style the pin is always driven. In both styles the request is active low.

The read port is registered. The data of a read appears in the cycle after the strobe, and the clearing takes effect at that same clock edge.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous active-low reset, all pending bits are zero, `rd_data_o` is 0x00 and `irq_o` is 1 (inactive).
- R2: An event pulse on bit b of source slot k sets pending bit b of register k at the next clock edge. That bit stays set until register k is read.
- R3: A read strobe at address k+1 (k = 0..NUM_REGS-1) returns pending register k on `rd_data_o` in the next cycle and clears that register. A second read then returns 0x00.
- R4: An event arriving in the same cycle as a clearing read of its register is not lost. That read returns the old contents, and the next read returns the new bit.
- R5: Address 0 returns the summary register, zero-extended. Bit k of the summary is 1 when register k has any pending bit, whether or not that bit is enabled. Reading the summary clears nothing.
- R6: `irq_o` is 0 exactly when at least one pending bit has its enable bit set. Pending bits whose enable is 0 do not activate `irq_o`.
- R7: `irq_o` returns to 1 in the cycle after the read that clears the last enabled pending bit.
- R8: `drive_cfg_i[0]` = 1 selects push-pull, and `irq_oe_o` is then always 1. `drive_cfg_i[0]` = 0 selects open drain, and `irq_oe_o` then equals the active request. `drive_cfg_i[1]` has no effect. Whenever `irq_oe_o` is 0, `irq_o` is 1.
- R9: A read at an address above NUM_REGS returns 0x00 and clears no register.
- R10: `rd_data_o` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | NUM_REGS*REG_W | Event pulses; slot k occupies bits [k*REG_W +: REG_W] |
| irq_en_i | input | NUM_REGS*REG_W | Per-bit enable of the request, same layout as `evt_i` |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Read address: 0 is the summary, k+1 is pending register k |
| rd_data_o | output | REG_W | Registered read data |
| drive_cfg_i | input | 2 | Pin drive style; bit 0 set means push-pull |
| irq_o | output | 1 | Request output value, active low |
| irq_oe_o | output | 1 | Request output enable |

## Verification
The assertions assume that events are held for exactly one cycle at a time, and that enables and the drive field are changed only while no read is in flight. The clear-on-read properties also assume that the read address is stable during the strobe cycle. The bench drives every input at the falling clock edge and raises events only in single-cycle steps, so these conditions hold. It releases each event and strobe before the next step. It changes the drive field between reads only, and it changes the enable mask only while the affected register is empty.

// File: rtl/irq_hub_pkg.sv
// Package irq_hub_pkg
// Shared pin-drive style type and the decode of the 2-bit drive field.
// Assumes the field is static while the interrupt is in use.
package irq_hub_pkg;

    typedef enum logic {
        DRV_OPEN_DRAIN = 1'b0,
        DRV_PUSH_PULL  = 1'b1
    } drive_style_t;

    // Map every value of the drive field to a style; the upper bit is reserved.
    function automatic drive_style_t decode_drive(input logic [1:0] cfg);
        drive_style_t style;
        case (cfg)
            2'b00:   style = DRV_OPEN_DRAIN;
            2'b01:   style = DRV_PUSH_PULL;
            2'b10:   style = DRV_OPEN_DRAIN;
            default: style = DRV_PUSH_PULL;
        endcase
        return style;
    endfunction

endpackage

// File: rtl/irq_stat_reg.sv
// Module irq_stat_reg
// One clear-on-read pending register. Event pulses set bits; a clear
// strobe empties the register, but events in the clearing cycle survive.
// Assumes clr_i lasts one cycle per read.
module irq_stat_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] stat_q;

    // Accumulate events; clear on read while keeping same-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (clr_i ? '0 : stat_q) | evt_i;
        end
    end

    assign stat_o = stat_q;

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i == '0) |=> (stat_o == '0)); // R3

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i))); // R4

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && evt_i == '0) |=> $stable(stat_o)); // R2

endmodule

// File: rtl/irq_read_mux.sv
// Module irq_read_mux
// Decodes the read address: 0 selects the summary, k+1 selects pending
// register k. It issues the clear strobe for a selected register and
// registers the read data. Unmapped addresses return zero and clear nothing.
// Assumes NUM <= W so that the summary fits in one data word.
module irq_read_mux #(
    parameter int NUM = 4,
    parameter int W   = 8,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM*W-1:0] stat_i,
    input  logic           rd_en_i,
    input  logic [AW-1:0]  rd_addr_i,
    output logic [NUM-1:0] clr_o,
    output logic [W-1:0]   rd_data_o
);

    logic [W-1:0] summary;
    logic [W-1:0] sel_data;
    logic [W-1:0] rd_data_q;

    // Build the zero-extended summary: one bit per pending register.
    always_comb begin
        summary = '0;
        for (int k = 0; k < NUM; k++) begin
            summary[k] = |stat_i[k*W +: W];
        end
    end

    // Select the read word and raise the clear for a read register.
    always_comb begin
        sel_data = '0;
        clr_o    = '0;
        if (rd_addr_i == '0) begin
            sel_data = summary;
        end
        for (int k = 0; k < NUM; k++) begin
            if (rd_addr_i == AW'(k + 1)) begin
                sel_data = stat_i[k*W +: W];
                clr_o[k] = rd_en_i;
            end
        end
    end

    // Capture the read word on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_en_i) begin
            rd_data_q <= sel_data;
        end
    end

    assign rd_data_o = rd_data_q;

    AST_READ_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o)); // R10

    AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o)); // R9

endmodule

// File: rtl/irq_pin_drive.sv
// Module irq_pin_drive
// Turns the active request into a pin value and an output enable for
// the chosen drive style. The request is shown active low in both styles.
// Assumes the drive field is quasi-static.
module irq_pin_drive
    import irq_hub_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [1:0] drive_cfg_i,
    output logic       irq_o,
    output logic       irq_oe_o
);

    drive_style_t style;

    // Resolve the style, the pin value and the enable.
    always_comb begin
        style    = decode_drive(drive_cfg_i);
        irq_o    = ~req_i;
        irq_oe_o = (style == DRV_PUSH_PULL) | req_i;
    end

    AST_NO_LOW_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_oe_o |-> irq_o); // R8

endmodule

// File: rtl/irq_hub.sv
// Module irq_hub
// Top of the aggregator. It holds one pending register per event slot,
// the shared read port with its summary word, and the request pin driver.
// Assumes events are single-cycle pulses and enables are static.
module irq_hub #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REGS*REG_W-1:0] evt_i,
    input  logic [NUM_REGS*REG_W-1:0] irq_en_i,
    input  logic                      rd_en_i,
    input  logic [ADDR_W-1:0]         rd_addr_i,
    output logic [REG_W-1:0]          rd_data_o,
    input  logic [1:0]                drive_cfg_i,
    output logic                      irq_o,
    output logic                      irq_oe_o
);

    localparam int TOTAL = NUM_REGS * REG_W;

    logic [TOTAL-1:0]    stat_all;
    logic [NUM_REGS-1:0] clr;
    logic                req;

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_slot
            irq_stat_reg #(.W(REG_W)) u_stat (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt_i  (evt_i[g*REG_W +: REG_W]),
                .clr_i  (clr[g]),
                .stat_o (stat_all[g*REG_W +: REG_W])
            );
        end
    endgenerate

    irq_read_mux #(.NUM(NUM_REGS), .W(REG_W), .AW(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_i    (stat_all),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    // Combine the enabled pending bits into one request.
    always_comb begin
        req = |(stat_all & irq_en_i);
    end

    irq_pin_drive u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .drive_cfg_i (drive_cfg_i),
        .irq_o       (irq_o),
        .irq_oe_o    (irq_oe_o)
    );

    AST_SUMMARY_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == '0 && evt_i == '0) |=> $stable(stat_all)); // R5

    AST_RELEASE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0 && (stat_all & irq_en_i & ~{TOTAL{1'b0}}) != '0 && $stable(irq_en_i)
         && ((stat_all & irq_en_i) & ~({REG_W{1'b1}} << 0)) == '0 && clr[0]) |=> irq_o); // R7

endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;

    localparam int NR = 4;
    localparam int RW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NR*RW-1:0] evt;
    logic [NR*RW-1:0] en;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [RW-1:0] rd_data;
    logic [1:0]    cfg;
    logic          irq;
    logic          irq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_hub #(.NUM_REGS(NR), .REG_W(RW), .ADDR_W(AW)) u_irq_hub (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .irq_en_i(en),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .drive_cfg_i(cfg), .irq_o(irq), .irq_oe_o(irq_oe)
    );

    // Vector: [23:22] slot, [21:14] event bits, [13] read, [12:9] addr,
    // [8:1] expected read data, [0] expected irq_o.
    localparam logic [23:0] VEC [12] = '{
        {2'd0, 8'h00, 1'b1, 4'd0, 8'h00, 1'b1},  // R5 summary empty
        {2'd0, 8'h05, 1'b0, 4'd0, 8'h00, 1'b0},  // R2 R6
        {2'd2, 8'h80, 1'b1, 4'd0, 8'h01, 1'b0},  // R5
        {2'd0, 8'h00, 1'b1, 4'd0, 8'h05, 1'b0},  // R5 no clear
        {2'd0, 8'h00, 1'b1, 4'd1, 8'h05, 1'b0},  // R3
        {2'd0, 8'h00, 1'b1, 4'd1, 8'h00, 1'b0},  // R3
        {2'd2, 8'h01, 1'b1, 4'd3, 8'h80, 1'b0},  // R4
        {2'd0, 8'h00, 1'b1, 4'd3, 8'h01, 1'b1},  // R4 R7
        {2'd0, 8'h00, 1'b1, 4'd3, 8'h00, 1'b1},  // R3
        {2'd3, 8'h40, 1'b1, 4'd9, 8'h00, 1'b0},  // R9
        {2'd0, 8'h00, 1'b1, 4'd4, 8'h40, 1'b1},  // R3 R7
        {2'd0, 8'h00, 1'b0, 4'd0, 8'h40, 1'b1}   // R10
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one step at a falling edge; return at the next falling edge.
    task automatic step(input int slot, input logic [7:0] bits,
                        input logic rd, input logic [AW-1:0] addr);
        evt = '0;
        evt[slot*RW +: RW] = bits;
        rd_en   = rd;
        rd_addr = addr;
        @(negedge clk);
        evt   = '0;
        rd_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; evt = '0; en = '1; rd_en = 1'b0; rd_addr = '0; cfg = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 irq_o", {7'd0, irq}, 8'h01);

        for (int i = 0; i < 12; i++) begin
            step(int'(VEC[i][23:22]), VEC[i][21:14], VEC[i][13], VEC[i][12:9]);
            chk($sformatf("R2-table v%0d data", i), rd_data, VEC[i][8:1]);
            chk($sformatf("R6-table v%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        // R6: disabled bits record but do not request.
        en[15:8] = 8'h00;
        step(1, 8'h0F, 1'b0, 4'd0);
        chk("R6 masked irq", {7'd0, irq}, 8'h01);
        step(0, 8'h00, 1'b1, 4'd0);
        chk("R5 summary masked", rd_data, 8'h02);
        step(0, 8'h00, 1'b1, 4'd2);
        chk("R3 masked read", rd_data, 8'h0F);
        step(0, 8'h00, 1'b1, 4'd2);
        chk("R3 masked reread", rd_data, 8'h00);
        en = '1;

        // R8: drive styles.
        cfg = 2'b00;
        step(0, 8'h00, 1'b0, 4'd0);
        chk("R8 od idle oe", {7'd0, irq_oe}, 8'h00);
        chk("R8 od idle irq", {7'd0, irq}, 8'h01);
        step(0, 8'h01, 1'b0, 4'd0);
        chk("R8 od active oe", {7'd0, irq_oe}, 8'h01);
        chk("R8 od active irq", {7'd0, irq}, 8'h00);
        cfg = 2'b10; #1;
        chk("R8 cfg10 active oe", {7'd0, irq_oe}, 8'h01);
        @(negedge clk);
        step(0, 8'h00, 1'b1, 4'd1);
        chk("R8 read data", rd_data, 8'h01);
        chk("R8 cfg10 idle oe", {7'd0, irq_oe}, 8'h00);
        cfg = 2'b11; #1;
        chk("R8 cfg11 idle oe", {7'd0, irq_oe}, 8'h01);
        cfg = 2'b01;
        @(negedge clk);

        // R9: unmapped read clears nothing.
        step(0, 8'h02, 1'b0, 4'd0);
        step(0, 8'h00, 1'b1, 4'd7);
        chk("R9 unmapped data", rd_data, 8'h00);
        chk("R9 irq kept", {7'd0, irq}, 8'h00);
        step(0, 8'h00, 1'b1, 4'd1);
        chk("R9 reg intact", rd_data, 8'h02);

        // R1: reset while pending.
        step(2, 8'h10, 1'b0, 4'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid irq_o", {7'd0, irq}, 8'h01);
        chk("R1 mid data", rd_data, 8'h00);
        step(0, 8'h00, 1'b1, 4'd0);
        chk("R1 summary", rd_data, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule